// File: doc/BRIEF.md
# System Reset Sequencer with Boot-Mode Capture

This block produces the single system reset of a small processor subsystem. Four sources can start it: power coming up, a bidirectional reset pin, an expiring software watchdog, and a failed clock monitor. Power-up holds reset for a long fixed count of clock cycles. The pin counts as a reset only once it has stayed low for a qualification window. The two internal sources start reset at once. They also pull the reset pin low, so that logic outside the block sees the event.

When reset ends, the block samples two boot-mode pins. It decodes them into four mode control bits. It keeps a record of what caused the last reset and uses it, together with the captured mode, to choose the address from which the processor fetches its start vector. While reset is active, the block asks the processor to set its three interrupt and stop mask bits.

Top module: `rst_seq_top`

## Requirements
- R1: After `pwr_good` rises, `sys_rst` stays 1 through the 4064th rising clock edge and goes to 0 on the 4065th, provided no other source is active.
- R2: The pin `rst_pin_n` starts a reset only when it is sampled low on 8 consecutive edges: `sys_rst` rises on the 9th edge. A low pulse of 7 edges has no effect.
- R3: `sys_rst` goes to 0 on the second edge after the last active source clears, for example the second edge after the pin returns high.
- R4: `wdog_expire`, or `clkmon_fail` while `clkmon_en` is 1, sets `sys_rst` on the same edge that samples it. `clkmon_fail` while `clkmon_en` is 0 is ignored.
- R5: `{mode_b, mode_a}` is captured on the edge where `sys_rst` falls. Changes to these pins at any other time leave `mode_ctl` and `reset_vec` unchanged.
- R6: `mode_ctl[3:0]` holds the bits boot-ROM, special, mode-A and internal-visibility, in that order. `{mode_b, mode_a}` = 11 gives 0000, 10 gives 0010, 01 gives 1101 and 00 gives 0111.
- R7: `mask_set` is 3'b111 while `sys_rst` is 1 and 3'b000 otherwise.
- R8: An internal source drives `rst_drive_low` to 1 starting on the edge that samples the source, for 8 cycles.
- R9: `rst_cause` codes are 0 power-on, 1 pin, 2 watchdog and 3 clock monitor. The cause is chosen when reset starts, with priority power-on > clock monitor > watchdog > pin. It stays fixed until a new reset starts, and power loss during any reset overrides it with 0.
- R10: `reset_vec` is 16'hFFFC for a clock-monitor cause and 16'hFFFA for a watchdog cause. For power-on and pin causes it is 16'hFFFE when the captured `mode_b` is 1 and 16'hBFFE when it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| pwr_good | input | 1 | Power-valid indication; low clears the block asynchronously |
| rst_pin_n | input | 1 | Level seen on the bidirectional reset pin |
| rst_drive_low | output | 1 | Pulls the reset pin low |
| wdog_expire | input | 1 | Watchdog timeout pulse |
| clkmon_fail | input | 1 | Clock monitor failure indication |
| clkmon_en | input | 1 | Enables clock monitor resets |
| mode_a | input | 1 | Boot-mode pin A |
| mode_b | input | 1 | Boot-mode pin B |
| sys_rst | output | 1 | Internal system reset, active high |
| mask_set | output | 3 | Request to set the X, I and S mask bits |
| mode_ctl | output | 4 | Decoded mode control bits |
| reset_vec | output | 16 | Address of the start vector |
| rst_cause | output | 2 | Source of the last reset |

## Verification
The hardest case to reach is the hand-over inside an internal reset. The watchdog or clock-monitor trigger ends, the self-driven pin low carries the reset, and that low must itself qualify before the drive stops. If any of these steps is off by a cycle, `sys_rst` shows a one-cycle drop. The bench loops `rst_drive_low` back onto `rst_pin_n` through a wired-AND, as a board would. It then checks `sys_rst` and `rst_drive_low` at each edge around that hand-over. Loss of power during a reset the pin is already holding is a second hard case. The bench drops `pwr_good` mid-reset and checks that the cause becomes power-on.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    CAUSE_POR    = 2'd0,
    CAUSE_PIN    = 2'd1,
    CAUSE_WDOG   = 2'd2,
    CAUSE_CLKMON = 2'd3
  } rst_cause_e;

  // {mode_b, mode_a} -> {boot_rom, special, mode_a_ctl, int_visible}
  function automatic logic [3:0] mode_ctl_decode(input logic [1:0] pins);
    logic [3:0] r;
    case (pins)
      2'b11:   r = 4'b0000;
      2'b10:   r = 4'b0010;
      2'b01:   r = 4'b1101;
      default: r = 4'b0111;
    endcase
    return r;
  endfunction

  function automatic logic [15:0] vector_pick(input rst_cause_e c, input logic [1:0] pins);
    logic [15:0] r;
    case (c)
      CAUSE_CLKMON: r = 16'hFFFC;
      CAUSE_WDOG:   r = 16'hFFFA;
      default:      r = pins[1] ? 16'hFFFE : 16'hBFFE;
    endcase
    return r;
  endfunction

  function automatic rst_cause_e cause_pick(input logic clk_bad, input logic wdog,
                                            input logic pin);
    rst_cause_e r;
    if (clk_bad)   r = CAUSE_CLKMON;
    else if (wdog) r = CAUSE_WDOG;
    else if (pin)  r = CAUSE_PIN;
    else           r = CAUSE_POR;
    return r;
  endfunction

endpackage

// File: rtl/rst_pin_qual.sv
module rst_pin_qual #(
  parameter int QUAL_CYCLES = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_n,
  output logic qual_o
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] QMAX = CW'(QUAL_CYCLES);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)            low_cnt <= '0;
    else if (pin_n)         low_cnt <= '0;
    else if (low_cnt != QMAX) low_cnt <= low_cnt + 1'b1;
  end

  assign qual_o = (low_cnt == QMAX);

  // R2
  pin_low_seen_chk: assert property (@(posedge clk) disable iff (!arst_n)
    qual_o |-> $past(!pin_n));

endmodule

// File: rtl/rst_por_stretch.sv
module rst_por_stretch #(
  parameter int POR_CYCLES = 4064
) (
  input  logic clk,
  input  logic arst_n,
  output logic busy_o
);
  localparam int CW = $clog2(POR_CYCLES + 1);
  localparam logic [CW-1:0] PMAX = CW'(POR_CYCLES);

  logic [CW-1:0] por_cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)              por_cnt <= '0;
    else if (por_cnt != PMAX) por_cnt <= por_cnt + 1'b1;
  end

  assign busy_o = (por_cnt != PMAX);

  // R1
  por_count_mono_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !$past(busy_o) |-> !busy_o);

endmodule

// File: rtl/rst_drive_gen.sv
module rst_drive_gen #(
  parameter int DRIVE_CYCLES = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic trig_i,
  output logic drive_o
);
  localparam int CW = $clog2(DRIVE_CYCLES + 1);
  localparam logic [CW-1:0] DLOAD = CW'(DRIVE_CYCLES);

  logic [CW-1:0] drv_cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)            drv_cnt <= '0;
    else if (trig_i)        drv_cnt <= DLOAD;
    else if (drv_cnt != '0) drv_cnt <= drv_cnt - 1'b1;
  end

  assign drive_o = (drv_cnt != '0);

  // R8
  drive_start_chk: assert property (@(posedge clk) disable iff (!arst_n)
    trig_i |=> drive_o);

endmodule

// File: rtl/rst_mode_latch.sv
module rst_mode_latch
  import rst_seq_pkg::*;
(
  input  logic        clk,
  input  logic        arst_n,
  input  logic        capture_i,
  input  logic [1:0]  mode_pins_i,
  input  rst_cause_e  cause_i,
  output logic [3:0]  ctl_o,
  output logic [15:0] vec_o
);
  logic [1:0] mode_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)        mode_q <= 2'b11;
    else if (capture_i) mode_q <= mode_pins_i;
  end

  assign ctl_o = mode_ctl_decode(mode_q);
  assign vec_o = vector_pick(cause_i, mode_q);

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !capture_i |=> $stable(mode_q));

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
  import rst_seq_pkg::*;
#(
  parameter int POR_CYCLES   = 4064,
  parameter int QUAL_CYCLES  = 8,
  parameter int DRIVE_CYCLES = QUAL_CYCLES
) (
  input  logic        clk,
  input  logic        pwr_good,
  input  logic        rst_pin_n,
  output logic        rst_drive_low,
  input  logic        wdog_expire,
  input  logic        clkmon_fail,
  input  logic        clkmon_en,
  input  logic        mode_a,
  input  logic        mode_b,
  output logic        sys_rst,
  output logic [2:0]  mask_set,
  output logic [3:0]  mode_ctl,
  output logic [15:0] reset_vec,
  output logic [1:0]  rst_cause
);
  logic       por_busy;
  logic       pin_qual;
  logic       drv_busy;
  logic       clk_trig;
  logic       int_trig;
  logic       rst_req;
  logic       release_ev;
  logic       sys_rst_q;
  rst_cause_e cause_q;

  rst_por_stretch #(.POR_CYCLES(POR_CYCLES)) por_i (
    .clk(clk), .arst_n(pwr_good), .busy_o(por_busy));

  rst_pin_qual #(.QUAL_CYCLES(QUAL_CYCLES)) qual_i (
    .clk(clk), .arst_n(pwr_good), .pin_n(rst_pin_n), .qual_o(pin_qual));

  assign clk_trig = clkmon_fail & clkmon_en;
  assign int_trig = wdog_expire | clk_trig;

  rst_drive_gen #(.DRIVE_CYCLES(DRIVE_CYCLES)) drv_i (
    .clk(clk), .arst_n(pwr_good), .trig_i(int_trig), .drive_o(drv_busy));

  assign rst_req    = por_busy | pin_qual | drv_busy | int_trig;
  assign release_ev = sys_rst_q & ~rst_req;

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) sys_rst_q <= 1'b1;
    else           sys_rst_q <= rst_req;
  end

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good)                cause_q <= CAUSE_POR;
    else if (!sys_rst_q && rst_req) cause_q <= cause_pick(clk_trig, wdog_expire, pin_qual);
  end

  rst_mode_latch mode_i (
    .clk(clk), .arst_n(pwr_good), .capture_i(release_ev),
    .mode_pins_i({mode_b, mode_a}), .cause_i(cause_q),
    .ctl_o(mode_ctl), .vec_o(reset_vec));

  assign sys_rst       = sys_rst_q;
  assign mask_set      = {3{sys_rst_q}};
  assign rst_drive_low = drv_busy;
  assign rst_cause     = cause_q;

  // R1
  release_after_por_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(sys_rst_q) |-> !$past(por_busy));

  // R8
  drive_inside_reset_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(drv_busy) |-> sys_rst_q);

  // R9
  cause_frozen_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    $past(sys_rst_q) |-> $stable(cause_q));

  // R4
  wdog_reset_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    wdog_expire |=> sys_rst_q);

endmodule

// File: tb/rst_seq_top_tb_top.sv
module rst_seq_top_tb_top;
  logic        clk = 1'b0;
  logic        pwr_good, pin_ext, wdog, cfail, cen, ma, mb;
  logic        drive, srst;
  logic [2:0]  mask;
  logic [3:0]  ctl;
  logic [15:0] vec;
  logic [1:0]  cause;
  wire         pin_line = pin_ext & ~drive;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rst_seq_top dut_i (
    .clk(clk), .pwr_good(pwr_good), .rst_pin_n(pin_line), .rst_drive_low(drive),
    .wdog_expire(wdog), .clkmon_fail(cfail), .clkmon_en(cen),
    .mode_a(ma), .mode_b(mb), .sys_rst(srst), .mask_set(mask),
    .mode_ctl(ctl), .reset_vec(vec), .rst_cause(cause));

  // {mode[1:0], src[1:0], ctl[3:0], vec[15:0]}; src 1 pin, 2 wdog, 3 clkmon
  localparam logic [23:0] TBL [12] = '{
    {2'b11, 2'd1, 4'b0000, 16'hFFFE}, {2'b11, 2'd2, 4'b0000, 16'hFFFA},
    {2'b11, 2'd3, 4'b0000, 16'hFFFC}, {2'b10, 2'd1, 4'b0010, 16'hFFFE},
    {2'b10, 2'd2, 4'b0010, 16'hFFFA}, {2'b10, 2'd3, 4'b0010, 16'hFFFC},
    {2'b01, 2'd1, 4'b1101, 16'hBFFE}, {2'b01, 2'd2, 4'b1101, 16'hFFFA},
    {2'b01, 2'd3, 4'b1101, 16'hFFFC}, {2'b00, 2'd1, 4'b0111, 16'hBFFE},
    {2'b00, 2'd2, 4'b0111, 16'hFFFA}, {2'b00, 2'd3, 4'b0111, 16'hFFFC}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [1:0] src);
    case (src)
      2'd1: begin pin_ext = 1'b0; tick(10); pin_ext = 1'b1; tick(3); end
      2'd2: begin wdog = 1'b1; tick(1); wdog = 1'b0; tick(15); end
      default: begin cen = 1'b1; cfail = 1'b1; tick(1); cfail = 1'b0; tick(15); end
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    pwr_good = 1'b0; pin_ext = 1'b1; wdog = 1'b0; cfail = 1'b0; cen = 1'b0;
    ma = 1'b1; mb = 1'b1;
    tick(3);
    check("R1 reset at power loss", srst, 1);
    check("R9 cause power-on", cause, 0);
    check("R7 masks set", mask, 3'b111);

    pwr_good = 1'b1;
    tick(4064);
    check("R1 still held at 4064", srst, 1);
    tick(1);
    check("R1 released at 4065", srst, 0);
    check("R7 masks clear", mask, 3'b000);
    check("R10 normal vector", vec, 16'hFFFE);
    check("R6 single-chip bits", ctl, 4'b0000);

    pin_ext = 1'b0; tick(7); pin_ext = 1'b1; tick(4);
    check("R2 short pulse ignored", srst, 0);
    check("R2 cause untouched", cause, 0);

    pin_ext = 1'b0; tick(8);
    check("R2 not yet at 8", srst, 0);
    tick(1);
    check("R2 reset at 9", srst, 1);
    check("R9 cause pin", cause, 1);
    tick(3); pin_ext = 1'b1; tick(1);
    check("R3 held one edge", srst, 1);
    tick(1);
    check("R3 released", srst, 0);

    wdog = 1'b1; tick(1); wdog = 1'b0;
    check("R4 wdog immediate", srst, 1);
    check("R8 drive starts", drive, 1);
    tick(7);
    check("R8 drive last cycle", drive, 1);
    tick(1);
    check("R8 drive ends", drive, 0);
    check("R3 hand-over held", srst, 1);
    tick(1);
    check("R3 hand-over held 2", srst, 1);
    tick(1);
    check("R3 internal released", srst, 0);
    check("R9 cause wdog", cause, 2);

    cfail = 1'b1; cen = 1'b0; tick(1); cfail = 1'b0; tick(15);
    check("R4 disabled monitor ignored", srst, 0);
    check("R4 no drive when disabled", drive, 0);
    check("R4 cause kept", cause, 2);

    wdog = 1'b1; cfail = 1'b1; cen = 1'b1; tick(1); wdog = 1'b0; cfail = 1'b0; tick(20);
    check("R9 monitor beats wdog", cause, 3);
    check("R10 monitor vector", vec, 16'hFFFC);

    for (int i = 0; i < 12; i++) begin
      {mb, ma} = TBL[i][23:22];
      fire(TBL[i][21:20]);
      check("R6 table ctl", ctl, TBL[i][19:16]);
      check("R10 table vector", vec, TBL[i][15:0]);
      check("R9 table cause", cause, TBL[i][21:20]);
      check("R3 table released", srst, 0);
    end

    {mb, ma} = 2'b11; fire(2'd1);
    {mb, ma} = 2'b00; tick(5);
    check("R5 late pin change ignored ctl", ctl, 4'b0000);
    check("R5 late pin change ignored vec", vec, 16'hFFFE);

    pin_ext = 1'b0; tick(10);
    check("R9 pin reset active", cause, 1);
    pwr_good = 1'b0; tick(2);
    check("R9 power-on overrides", cause, 0);
    pwr_good = 1'b1; tick(4070);
    check("R2 pin still holds reset", srst, 1);
    pin_ext = 1'b1; tick(3);
    check("R3 released after por and pin", srst, 0);
    check("R9 cause stays power-on", cause, 0);
    check("R5 captured special test", ctl, 4'b0111);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule